// File: doc/BRIEF.md
# Branch and Condition Resolution Unit

This block picks the next program counter for a core that runs in two instruction states. The wide state uses 32-bit instructions. The compact state uses 16-bit instructions. The block takes instruction fields that have already been decoded, together with the current PC, the current state and the four arithmetic flags. It first decides whether the instruction's condition passes. It then works out where execution continues: either in sequence, or at a branch target taken from an immediate or from a register operand.

There are four branch kinds: a plain jump, a call that writes a link value, a state-switching jump, and a state-switching call. For the state-switching kinds, bit 0 of the target chooses the state that follows and is cleared in the new PC. All results are registered. They appear one clock after an input strobe, together with a one-cycle output strobe.

Top module: `branch_resolve`

## Requirements
- R1: Condition codes 0 to 13 are tested against the flags input, whose bits are N=bit 3, Z=bit 2, C=bit 1 and V=bit 0. The codes pass as follows:
  - 0 passes on Z, 1 on !Z.
  - 2 passes on C, 3 on !C.
  - 4 passes on N, 5 on !N.
  - 6 passes on V, 7 on !V.
  - 8 passes on C&&!Z, 9 on !C||Z.
  - 10 passes on N==V, 11 on N!=V.
  - 12 passes on !Z&&N==V, 13 on Z||N!=V.
- R2: Condition codes 14 and 15 pass for every flag value.
- R3: When the condition fails, the outputs are set as follows:
  - next PC is current PC plus the instruction size, which is 4 in wide state (cur_state=0) and 2 in compact state (cur_state=1);
  - the link write enable stays low;
  - the state does not change.
- R4: In compact state, an instruction is conditional only when half_op[15:12] is 0xD, and its condition code is half_op[11:8]. Every other compact opcode passes whatever the flags are, and wide_cond is not used.
- R5: When the register operand is selected (use_reg=1) and reg_idx is 15, the target is current PC plus twice the instruction size, and reg_val is not used.
- R6: For the state-switching kinds (br_kind 3 = switching jump, 4 = switching call), target bit 0 becomes the next state (1 = compact) and next PC is the target with bit 0 cleared.
- R7: For the call kinds (br_kind 2 and 4) when the condition passes, link_we is high for one output cycle and link_val is current PC + 4, plus 1 in compact state.
- R8: An instruction that is not a branch (br_kind 0, or the unused values 5 to 7) and passes its condition gives next PC = current PC + instruction size, with the state unchanged and no link write.
- R9: Outputs update one clock after in_valid is high. out_valid is high in exactly that cycle. Without a strobe, out_valid and link_we are low and next_pc and next_state hold their values.
- R10: Synchronous active-high reset clears out_valid, next_pc, next_state, link_we and link_val to zero.
- R11: For the plain jump (br_kind 1) and the plain call (br_kind 2), next PC is the target unchanged, and the state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe: the fields below are valid |
| cur_pc | input | AW | Address of the current instruction |
| cur_state | input | 1 | 0 = wide state, 1 = compact state |
| flags | input | 4 | N, Z, C, V in bits 3..0 |
| wide_cond | input | 4 | Condition field for wide state |
| half_op | input | 16 | Compact-state opcode |
| br_kind | input | 3 | 0 none, 1 jump, 2 call, 3 switching jump, 4 switching call |
| use_reg | input | 1 | 1 = target comes from a register operand |
| reg_idx | input | RW | Index of the register operand |
| reg_val | input | AW | Value of the register operand |
| imm_target | input | AW | Immediate branch target |
| out_valid | output | 1 | Result strobe |
| next_pc | output | AW | Resolved next program counter |
| next_state | output | 1 | Resolved instruction state |
| link_we | output | 1 | Link register write enable |
| link_val | output | AW | Value for the link register |

## Verification
The embedded assertions check the following on every cycle:
- one-cycle strobe timing and hold when idle;
- codes 14 and 15 always pass, and compact opcodes other than 0xD are unconditional;
- a failed condition never writes the link and keeps the state;
- a state-switching branch always gives an even PC;
- a passing call writes the correct link value.

Only the bench's sweeps can show that every one of the sixteen codes gives the right answer for all sixteen flag combinations in both states. The same holds for the target arithmetic under varied operands, including register 15.

// File: rtl/brcr_pkg.sv
package brcr_pkg;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_JUMP  = 3'd1,
    BK_CALL  = 3'd2,
    BK_XJUMP = 3'd3,
    BK_XCALL = 3'd4
  } br_kind_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  localparam logic [3:0] NARROW_COND_NIB = 4'hD;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import brcr_pkg::*;
(
  input  logic        state_i,
  input  logic [3:0]  wide_cond_i,
  input  logic [15:0] half_op_i,
  input  logic [3:0]  flags_i,
  output logic [3:0]  code_o,
  output logic        active_o,
  output logic        pass_o
);

  logic n_f, z_f, c_f, v_f;
  logic base;

  assign n_f = flags_i[FLG_N];
  assign z_f = flags_i[FLG_Z];
  assign c_f = flags_i[FLG_C];
  assign v_f = flags_i[FLG_V];

  // Effective condition source depends on the instruction state.
  always_comb begin
    if (state_i) begin
      active_o = (half_op_i[15:12] == NARROW_COND_NIB);
      code_o   = half_op_i[11:8];
    end else begin
      active_o = 1'b1;
      code_o   = wide_cond_i;
    end
  end

  // Codes come in pairs: odd code is the complement of the even one.
  always_comb begin
    unique case (code_o[3:1])
      3'd0:    base = z_f;
      3'd1:    base = c_f;
      3'd2:    base = n_f;
      3'd3:    base = v_f;
      3'd4:    base = c_f & ~z_f;
      3'd5:    base = (n_f == v_f);
      3'd6:    base = ~z_f & (n_f == v_f);
      default: base = 1'b1;
    endcase
  end

  always_comb begin
    if (!active_o)
      pass_o = 1'b1;
    else if (code_o[3:1] == 3'd7)
      pass_o = 1'b1;
    else
      pass_o = base ^ code_o[0];
  end

endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
  import brcr_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic          state_i,
  input  logic [2:0]    kind_i,
  input  logic          use_reg_i,
  input  logic [RW-1:0] reg_idx_i,
  input  logic [AW-1:0] reg_val_i,
  input  logic [AW-1:0] imm_i,
  output logic [AW-1:0] tgt_o,
  output logic          is_branch_o,
  output logic          is_exch_o,
  output logic          is_link_o
);

  localparam logic [RW-1:0] PC_REG   = RW'((1 << RW) - 1);
  localparam logic [AW-1:0] PC_AHEAD_WIDE   = AW'(8);
  localparam logic [AW-1:0] PC_AHEAD_NARROW = AW'(4);

  br_kind_e kind;
  assign kind = br_kind_e'(kind_i);

  always_comb begin
    is_branch_o = 1'b0;
    is_exch_o   = 1'b0;
    is_link_o   = 1'b0;
    case (kind)
      BK_JUMP:  is_branch_o = 1'b1;
      BK_CALL:  begin is_branch_o = 1'b1; is_link_o = 1'b1; end
      BK_XJUMP: begin is_branch_o = 1'b1; is_exch_o = 1'b1; end
      BK_XCALL: begin is_branch_o = 1'b1; is_exch_o = 1'b1; is_link_o = 1'b1; end
      default:  is_branch_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!use_reg_i)
      tgt_o = imm_i;
    else if (reg_idx_i == PC_REG)
      tgt_o = pc_i + (state_i ? PC_AHEAD_NARROW : PC_AHEAD_WIDE);
    else
      tgt_o = reg_val_i;
  end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import brcr_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] cur_pc,
  input  logic          cur_state,
  input  logic [3:0]    flags,
  input  logic [3:0]    wide_cond,
  input  logic [15:0]   half_op,
  input  logic [2:0]    br_kind,
  input  logic          use_reg,
  input  logic [RW-1:0] reg_idx,
  input  logic [AW-1:0] reg_val,
  input  logic [AW-1:0] imm_target,
  output logic          out_valid,
  output logic [AW-1:0] next_pc,
  output logic          next_state,
  output logic          link_we,
  output logic [AW-1:0] link_val
);

  localparam logic [AW-1:0] SZ_WIDE   = AW'(4);
  localparam logic [AW-1:0] SZ_NARROW = AW'(2);
  localparam logic [AW-1:0] LINK_OFS  = AW'(4);

  logic [3:0]    eff_code;
  logic          cond_active;
  logic          cond_pass;
  logic [AW-1:0] tgt;
  logic          is_branch, is_exch, is_link;

  br_cond_eval u_cond (
    .state_i     (cur_state),
    .wide_cond_i (wide_cond),
    .half_op_i   (half_op),
    .flags_i     (flags),
    .code_o      (eff_code),
    .active_o    (cond_active),
    .pass_o      (cond_pass)
  );

  br_target_calc #(.AW(AW), .RW(RW)) u_tgt (
    .pc_i        (cur_pc),
    .state_i     (cur_state),
    .kind_i      (br_kind),
    .use_reg_i   (use_reg),
    .reg_idx_i   (reg_idx),
    .reg_val_i   (reg_val),
    .imm_i       (imm_target),
    .tgt_o       (tgt),
    .is_branch_o (is_branch),
    .is_exch_o   (is_exch),
    .is_link_o   (is_link)
  );

  logic [AW-1:0] seq_pc, npc_d, lval_d;
  logic          nst_d, we_d;

  assign seq_pc = cur_pc + (cur_state ? SZ_NARROW : SZ_WIDE);
  assign lval_d = cur_pc + LINK_OFS + AW'(cur_state);

  always_comb begin
    npc_d = seq_pc;
    nst_d = cur_state;
    we_d  = 1'b0;
    if (cond_pass && is_branch) begin
      we_d = is_link;
      if (is_exch) begin
        npc_d = {tgt[AW-1:1], 1'b0};
        nst_d = tgt[0];
      end else begin
        npc_d = tgt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      next_pc    <= '0;
      next_state <= 1'b0;
      link_we    <= 1'b0;
      link_val   <= '0;
    end else begin
      out_valid <= in_valid;
      link_we   <= in_valid & we_d;
      if (in_valid) begin
        next_pc    <= npc_d;
        next_state <= nst_d;
        link_val   <= lval_d;
      end
    end
  end

  // R9: result strobe follows an input strobe by one cycle
  a_r9_strobe_to_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9: idle cycles hold the result and raise nothing
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !link_we && $stable(next_pc) && $stable(next_state)));

  // R2: always-codes pass whatever the flags
  a_r2_always_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_active && eff_code[3:1] == 3'd7) |-> cond_pass);

  // R4: compact opcodes outside the conditional nibble are unconditional
  a_r4_compact_uncond: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_state && half_op[15:12] != NARROW_COND_NIB) |-> cond_pass);

  // R3: a failed condition writes no link and keeps the state
  a_r3_fail_keeps: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_pass) |=> (!link_we && next_state == $past(cur_state)));

  // R6: state-switching branches always land on an even address
  a_r6_exch_even: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_pass && is_exch) |=> (next_pc[0] == 1'b0));

  // R7: a passing call writes PC+4 (+1 in compact state)
  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_pass && is_link) |=>
      (link_we && link_val == $past(cur_pc) + AW'(4) + AW'($past(cur_state))));

  // R7: link write only with a result strobe
  a_r7_link_with_valid: assert property (@(posedge clk) disable iff (rst)
    link_we |-> out_valid);

endmodule

// File: tb/sim_branch_resolve.sv
`timescale 1ns/1ps
module sim_branch_resolve;

  localparam int AW = 32;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] cur_pc = '0;
  logic          cur_state = 1'b0;
  logic [3:0]    flags = '0;
  logic [3:0]    wide_cond = '0;
  logic [15:0]   half_op = '0;
  logic [2:0]    br_kind = '0;
  logic          use_reg = 1'b0;
  logic [RW-1:0] reg_idx = '0;
  logic [AW-1:0] reg_val = '0;
  logic [AW-1:0] imm_target = '0;
  logic          out_valid, next_state, link_we;
  logic [AW-1:0] next_pc, link_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_resolve #(.AW(AW), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc),
    .cur_state(cur_state), .flags(flags), .wide_cond(wide_cond),
    .half_op(half_op), .br_kind(br_kind), .use_reg(use_reg),
    .reg_idx(reg_idx), .reg_val(reg_val), .imm_target(imm_target),
    .out_valid(out_valid), .next_pc(next_pc), .next_state(next_state),
    .link_we(link_we), .link_val(link_val)
  );

  // Independent reference for the condition table (flags = N Z C V)
  function automatic bit ref_cond(input logic [3:0] code, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  logic [AW-1:0] e_pc, e_lv;
  logic          e_st, e_we;
  bit            e_pass;

  task automatic model();
    logic [AW-1:0] sz, tgt;
    bit act;
    logic [3:0] code;
    sz = cur_state ? 32'd2 : 32'd4;
    if (cur_state) begin
      act = (half_op[15:12] == 4'hD);
      code = half_op[11:8];
    end else begin
      act = 1'b1;
      code = wide_cond;
    end
    e_pass = !act || ref_cond(code, flags);
    e_lv = cur_pc + 32'd4 + {31'd0, cur_state};
    e_pc = cur_pc + sz; e_st = cur_state; e_we = 1'b0;
    if (e_pass && br_kind >= 3'd1 && br_kind <= 3'd4) begin
      if (!use_reg) tgt = imm_target;
      else if (reg_idx == 4'd15) tgt = cur_pc + 2 * sz;
      else tgt = reg_val;
      e_we = (br_kind == 3'd2 || br_kind == 3'd4);
      if (br_kind >= 3'd3) begin
        e_pc = tgt & ~32'd1;
        e_st = tgt[0];
      end else begin
        e_pc = tgt;
      end
    end
  endtask

  task automatic run_op(input string tag, input logic st, input logic [3:0] wc,
                        input logic [15:0] op, input logic [3:0] fl,
                        input logic [2:0] kd, input logic ur, input logic [3:0] ri,
                        input logic [31:0] rv, input logic [31:0] im, input logic [31:0] pc);
    @(negedge clk);
    cur_state = st; wide_cond = wc; half_op = op; flags = fl; br_kind = kd;
    use_reg = ur; reg_idx = ri; reg_val = rv; imm_target = im; cur_pc = pc;
    in_valid = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || next_pc !== e_pc || next_state !== e_st ||
        link_we !== e_we || (e_we && link_val !== e_lv)) begin
      errors++;
      $display("FAIL %s: got v=%0b pc=%h st=%0b we=%0b lv=%h exp v=1 pc=%h st=%0b we=%0b lv=%h",
               tag, out_valid, next_pc, next_state, link_we, link_val,
               e_pc, e_st, e_we, e_lv);
    end
  endtask

  function automatic string sweep_tag(input bit st, input logic [15:0] op,
                                      input logic [3:0] wc, input bit pass);
    if (st && op[15:12] != 4'hD) return "R4";
    if (!pass) return "R3";
    if ((st ? op[11:8] : wc) >= 4'd14) return "R2";
    return "R1";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] hold_pc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || next_pc !== 0 || next_state !== 0 || link_we !== 0 || link_val !== 0) begin
      errors++;
      $display("FAIL R10: got v=%0b pc=%h st=%0b we=%0b lv=%h exp all zero",
               out_valid, next_pc, next_state, link_we, link_val);
    end
    rst = 1'b0;

    // Wide state: all codes x all flag combinations, mixed branch kinds
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        int i;
        logic [31:0] pc;
        i = c * 16 + f;
        pc = 32'h1000 + i * 8;
        run_op(sweep_tag(0, 16'h0, 4'(c), ref_cond(4'(c), 4'(f))),
               1'b0, 4'(c), 16'h0, 4'(f), 3'(i % 5), (i % 3) == 0,
               (i % 7 == 0) ? 4'd15 : 4'(i % 15), 32'h8000_0000 ^ (i * 13),
               32'h0002_0000 + i * 6 + (i & 1), pc);
      end
    end

    // Compact state: every top nibble x code x flags
    for (int nb = 0; nb < 16; nb++) begin
      for (int c = 0; c < 16; c++) begin
        for (int f = 0; f < 16; f++) begin
          int i;
          logic [15:0] op;
          bit p;
          i = nb * 256 + c * 16 + f;
          op = {4'(nb), 4'(c), 8'hA5};
          p = (nb != 13) || ref_cond(4'(c), 4'(f));
          run_op(sweep_tag(1, op, 4'(i % 16), p),
                 1'b1, 4'(i % 16), op, 4'(f), 3'(i % 8), (i % 3) == 1,
                 (i % 5 == 0) ? 4'd15 : 4'(i % 13), 32'h4000_0001 + i * 10,
                 32'h0003_0000 + i * 4 + (i % 2), 32'h9000 + i * 2);
        end
      end
    end

    // R5: register 15 operand reads PC + 2*size
    run_op("R5", 1'b0, 4'd14, 16'h0, 4'h0, 3'd1, 1'b1, 4'd15, 32'hDEAD_BEEF, 32'h0, 32'h100);
    if (next_pc !== 32'h108) begin errors++; $display("FAIL R5: got %h exp 00000108", next_pc); end
    checks++;
    run_op("R5", 1'b1, 4'd0, 16'h4000, 4'h0, 3'd3, 1'b1, 4'd15, 32'hDEAD_BEEF, 32'h0, 32'h200);
    // R6: switching branches take state from bit 0
    run_op("R6", 1'b0, 4'd14, 16'h0, 4'h0, 3'd3, 1'b0, 4'd0, 32'h0, 32'h3001, 32'h40);
    checks++;
    if (next_pc !== 32'h3000 || next_state !== 1'b1) begin
      errors++; $display("FAIL R6: got pc=%h st=%0b exp pc=00003000 st=1", next_pc, next_state);
    end
    run_op("R6", 1'b1, 4'd0, 16'h4000, 4'h0, 3'd4, 1'b0, 4'd0, 32'h0, 32'h4000, 32'h50);
    // R7: link values in both states
    run_op("R7", 1'b1, 4'd0, 16'hDE00, 4'h0, 3'd2, 1'b0, 4'd0, 32'h0, 32'h8000, 32'h500);
    checks++;
    if (link_we !== 1'b1 || link_val !== 32'h505) begin
      errors++; $display("FAIL R7: got we=%0b lv=%h exp we=1 lv=00000505", link_we, link_val);
    end
    run_op("R7", 1'b0, 4'd14, 16'h0, 4'h0, 3'd2, 1'b0, 4'd0, 32'h0, 32'h8000, 32'h600);
    // R11: plain jump keeps odd target and state
    run_op("R11", 1'b0, 4'd14, 16'h0, 4'h0, 3'd1, 1'b0, 4'd0, 32'h0, 32'h7003, 32'h700);
    checks++;
    if (next_pc !== 32'h7003 || next_state !== 1'b0) begin
      errors++; $display("FAIL R11: got pc=%h st=%0b exp pc=00007003 st=0", next_pc, next_state);
    end
    // R8: non-branch passes -> sequential
    run_op("R8", 1'b1, 4'd0, 16'h1234, 4'h0, 3'd0, 1'b0, 4'd0, 32'h0, 32'hFFFF_0000, 32'h800);
    run_op("R8", 1'b0, 4'd15, 16'h0, 4'hF, 3'd6, 1'b1, 4'd3, 32'h1111, 32'h2222, 32'h900);
    // R3: failed call in compact state writes no link
    run_op("R3", 1'b1, 4'd0, 16'hD0FF, 4'h0, 3'd4, 1'b0, 4'd0, 32'h0, 32'h5001, 32'hA00);

    // R9: idle cycle holds results and drops strobes
    hold_pc = next_pc;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || link_we !== 1'b0 || next_pc !== hold_pc) begin
      errors++;
      $display("FAIL R9: got v=%0b we=%0b pc=%h exp v=0 we=0 pc=%h",
               out_valid, link_we, next_pc, hold_pc);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule